// File: doc/BRIEF.md
# Tagged integer arithmetic unit

This execution unit works on words from dynamically typed runtimes, where the low bits of each word hold a small type tag and the remaining upper bits hold a two's complement small integer. Each operation comes with a 6-bit tag specification. The specification chooses how many low bits form the tag, from one to four, and gives the tag value that both operands must carry. The unit supports add, subtract and compare on two tagged operands. It also supports add and subtract with a signed immediate, which is moved up past the tag field before use.

The unit does not trap. When an operand carries the wrong tag, or when the arithmetic on the integer field does not fit, it raises a skip indication. The surrounding pipeline uses this indication to annul the instruction that follows, which is normally the branch around a slow generic path. When skip is low, an add or subtract result comes back with the required tag in its low bits, ready to be stored. A compare returns equal and signed less-than flags. All outputs are registered and appear one clock after the input strobe.

Top module: `tagged_int_alu`

## Requirements
- R1: Bits [5:4] of `in_spec` select the tag width as 1, 2, 3 or 4 low bits for codes 00, 01, 10 and 11. Bits [3:0] give the required tag value. Any value bit at or above the selected width has no effect.
- R2: Opcodes are 000 add, 001 subtract, 010 compare, 100 add-immediate and 101 subtract-immediate. For a register form, `out_skip` rises when either operand's tag bits differ from the required tag.
- R3: For add forms, `out_skip` rises when the signed sum of the integer fields (the word with its tag bits removed) does not fit in the DATA_W minus tag-width bits.
- R4: For subtract forms, `out_skip` rises when the signed difference A minus B of the integer fields does not fit in that field.
- R5: When skip is low, an add or subtract result holds the integer-field result in its upper bits and the required tag in its low tag bits.
- R6: Compare raises skip only on a tag mismatch, never on overflow. `out_eq` reports equal integer fields and `out_lt` reports a signed A below B. Both flags are meaningful only when skip is low.
- R7: The immediate forms sign-extend the IMM_W-bit `in_imm`, shift it left by the tag width, and use it as operand B. Only operand A's tag is checked, and `in_b` has no effect.
- R8: `out_valid` equals `in_valid` delayed by one clock. An active-low asynchronous reset clears `out_valid`.
- R9: When `in_valid` is low, the result, skip and flag outputs keep their previous values.
- R10: The opcodes 011, 110 and 111 are reserved and always produce skip.
- R11: With DATA_W set to 64, R1 through R7 hold for every tag width from 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code |
| in_a | input | DATA_W | Tagged operand A |
| in_b | input | DATA_W | Tagged operand B |
| in_imm | input | IMM_W | Signed untagged immediate |
| in_spec | input | 6 | Tag width code and required tag |
| out_valid | output | 1 | Result strobe |
| out_result | output | DATA_W | Retagged result, undefined when skip is high |
| out_skip | output | 1 | Annul-next indication |
| out_eq | output | 1 | Compare: fields equal |
| out_lt | output | 1 | Compare: A less than B, signed |

## Verification
The unit holds no state other than its output register, so any internal fault appears at the ports in the very next clock. A wrong mask decode or a missing tag reinsertion shows up as a wrong skip or wrong low result bits on the following out_valid cycle. An overflow taken from the wrong bit position shows up only near the edges of the integer range, which is why the bench drives values at the field limits for every tag width. A load enable that is gated wrongly shows up as outputs that change during idle cycles.

// File: rtl/tagint_pkg.sv
package tagint_pkg;

  localparam int SPEC_W   = 6;
  localparam int TAGW_MAX = 4;
  localparam int SHW      = 3;

  typedef enum logic [2:0] {
    TOP_ADD  = 3'b000,
    TOP_SUB  = 3'b001,
    TOP_CMP  = 3'b010,
    TOP_ADDI = 3'b100,
    TOP_SUBI = 3'b101
  } tag_op_e;

  function automatic logic [SHW-1:0] width_of(input logic [1:0] code);
    return SHW'(code) + SHW'(1);
  endfunction

endpackage

// File: rtl/tagint_spec_dec.sv
module tagint_spec_dec
  import tagint_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SPEC_W-1:0] spec,
  output logic [DATA_W-1:0] tag_mask,
  output logic [DATA_W-1:0] tag_pat,
  output logic [SHW-1:0]    tag_w
);

  assign tag_w = width_of(spec[5:4]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < TAGW_MAX) begin : g_tag
      assign tag_mask[i] = (SHW'(i) < tag_w);
      assign tag_pat[i]  = spec[i] & tag_mask[i];
    end else begin : g_field
      assign tag_mask[i] = 1'b0;
      assign tag_pat[i]  = 1'b0;
    end
  end

endmodule

// File: rtl/tagint_tag_chk.sv
module tagint_tag_chk #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] tag_mask,
  input  logic [DATA_W-1:0] tag_pat,
  output logic              match,
  output logic [DATA_W-1:0] field
);

  assign match = (((word ^ tag_pat) & tag_mask) == '0);
  assign field = word & ~tag_mask;

endmodule

// File: rtl/tagint_arith.sv
module tagint_arith #(
  parameter int DATA_W = 32
) (
  input  logic              do_sub,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              ovf,
  output logic              eq,
  output logic              lt
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              carry_in;

  always_comb begin
    b_eff    = do_sub ? ~b : b;
    carry_in = do_sub;
    res      = a + b_eff + DATA_W'(carry_in);
    ovf      = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
    eq       = (a == b);
    lt       = ($signed(a) < $signed(b));
  end

  always_comb begin
    if (!do_sub && (a[MSB] != b[MSB])) begin
      a_r3_no_overflow : assert (!ovf);
    end
    if (do_sub && (a[MSB] == b[MSB])) begin
      a_r4_no_overflow : assert (!ovf);
    end
  end

endmodule

// File: rtl/tagged_int_alu.sv
module tagged_int_alu
  import tagint_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [SPEC_W-1:0] in_spec,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_skip,
  output logic              out_eq,
  output logic              out_lt
);

  localparam int N_OPND = 2;

  logic [DATA_W-1:0] tag_mask, tag_pat;
  logic [SHW-1:0]    tag_w;
  logic              is_add, is_sub, is_cmp, use_imm, op_ok;
  logic [DATA_W-1:0] imm_ext, imm_word;
  logic [DATA_W-1:0] opnd  [N_OPND];
  logic [DATA_W-1:0] field [N_OPND];
  logic [N_OPND-1:0] match;
  logic [DATA_W-1:0] sum;
  logic              ovf, f_eq, f_lt;

  logic              nxt_valid, nxt_skip, nxt_eq, nxt_lt;
  logic [DATA_W-1:0] nxt_result;
  logic              load_en;

  tagint_spec_dec #(.DATA_W(DATA_W)) u_dec (
    .spec     (in_spec),
    .tag_mask (tag_mask),
    .tag_pat  (tag_pat),
    .tag_w    (tag_w)
  );

  always_comb begin
    is_add  = (in_op == TOP_ADD) || (in_op == TOP_ADDI);
    is_sub  = (in_op == TOP_SUB) || (in_op == TOP_SUBI);
    is_cmp  = (in_op == TOP_CMP);
    use_imm = (in_op == TOP_ADDI) || (in_op == TOP_SUBI);
    op_ok   = is_add || is_sub || is_cmp;
    imm_ext = {{(DATA_W-IMM_W){in_imm[IMM_W-1]}}, in_imm};
    imm_word = (imm_ext << tag_w) | tag_pat;
    opnd[0] = in_a;
    opnd[1] = use_imm ? imm_word : in_b;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    tagint_tag_chk #(.DATA_W(DATA_W)) u_chk (
      .word     (opnd[g]),
      .tag_mask (tag_mask),
      .tag_pat  (tag_pat),
      .match    (match[g]),
      .field    (field[g])
    );
  end

  tagint_arith #(.DATA_W(DATA_W)) u_arith (
    .do_sub (is_sub || is_cmp),
    .a      (field[0]),
    .b      (field[1]),
    .res    (sum),
    .ovf    (ovf),
    .eq     (f_eq),
    .lt     (f_lt)
  );

  // next-state
  always_comb begin
    nxt_valid  = in_valid;
    load_en    = in_valid;
    nxt_skip   = !op_ok || !(&match) || (!is_cmp && ovf);
    nxt_result = sum | tag_pat;
    nxt_eq     = f_eq;
    nxt_lt     = f_lt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
      out_skip   <= 1'b0;
      out_eq     <= 1'b0;
      out_lt     <= 1'b0;
    end else if (load_en) begin
      out_result <= nxt_result;
      out_skip   <= nxt_skip;
      out_eq     <= nxt_eq;
      out_lt     <= nxt_lt;
    end
  end

  a_r8_valid_follow : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_skip) && $stable(out_eq) && $stable(out_lt)));

  a_r2_mismatch_skip : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(&match)) |=> out_skip);

  a_r10_reserved_skip : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_ok) |=> out_skip);

  a_r5_tag_kept : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (is_add || is_sub)) |=>
      (out_skip || ((out_result & $past(tag_mask)) == $past(tag_pat))));

  a_r6_flags_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_skip && out_eq) |-> !out_lt);

endmodule

// File: tb/tagged_int_alu_bench.sv
`timescale 1ns/1ps
module tagged_int_alu_bench;

  localparam int IMM_W = 16;

  typedef struct {
    bit          vld;
    bit          skip;
    logic [63:0] res;
    bit          eq;
    bit          lt;
    bit          is_cmp;
    string       req_skip;
    string       req_res;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic              in_valid;
  logic [2:0]        in_op;
  logic [IMM_W-1:0]  in_imm;
  logic [5:0]        in_spec;
  logic [31:0]       a32, b32;
  logic [63:0]       a64, b64;

  logic              v32, s32, e32, l32;
  logic [31:0]       r32;
  logic              v64, s64, e64, l64;
  logic [63:0]       r64;

  int n_checks = 0;
  int n_fail   = 0;

  exp_t        pend [2];
  logic [63:0] last_res [2];
  logic        last_sk  [2];

  tagged_int_alu #(.DATA_W(32), .IMM_W(IMM_W)) u_tagged_int_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(a32), .in_b(b32), .in_imm(in_imm), .in_spec(in_spec),
    .out_valid(v32), .out_result(r32), .out_skip(s32), .out_eq(e32), .out_lt(l32)
  );

  tagged_int_alu #(.DATA_W(64), .IMM_W(IMM_W)) u_tagged_int_alu_w64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(a64), .in_b(b64), .in_imm(in_imm), .in_spec(in_spec),
    .out_valid(v64), .out_result(r64), .out_skip(s64), .out_eq(e64), .out_lt(l64)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint sx(input int w, input logic [63:0] v);
    longint r;
    if (w == 64) r = longint'(v);
    else r = longint'({{32{v[31]}}, v[31:0]});
    return r;
  endfunction

  // behavioural reference built from the requirements
  function automatic exp_t model(input int w, input bit vld, input logic [2:0] op,
                                 input logic [63:0] a, input logic [63:0] b,
                                 input logic [15:0] imm, input logic [5:0] spec);
    exp_t   e;
    int     tw;
    longint va, vb, r, lim;
    logic [63:0] mask, pat, wmask;
    bit     add, sub, cmp, imm_f, am, bm;
    tw    = int'(spec[5:4]) + 1;
    mask  = (64'd1 << tw) - 64'd1;
    pat   = {60'd0, spec[3:0]} & mask;
    wmask = (w == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
    add   = (op == 3'b000) || (op == 3'b100);
    sub   = (op == 3'b001) || (op == 3'b101);
    cmp   = (op == 3'b010);
    imm_f = (op == 3'b100) || (op == 3'b101);
    va    = sx(w, a) >>> tw;
    vb    = imm_f ? longint'($signed(imm)) : (sx(w, b) >>> tw);
    am    = ((a & mask) == pat);
    bm    = imm_f || ((b & mask) == pat);
    lim   = longint'(64'd1 << (w - tw - 1));
    r     = sub ? (va - vb) : (va + vb);
    e.vld    = vld;
    e.is_cmp = cmp;
    e.eq     = (va == vb);
    e.lt     = (va < vb);
    e.res    = ((r << tw) | pat) & wmask;
    if (!(add || sub || cmp)) begin
      e.skip = 1'b1; e.req_skip = "R10";
    end else if (!am || !bm) begin
      e.skip = 1'b1; e.req_skip = "R2";
    end else begin
      e.skip = !cmp && ((r >= lim) || (r < -lim));
      if (imm_f) e.req_skip = "R7";
      else if (cmp) e.req_skip = "R6";
      else if ((spec[3:0] & ~mask[3:0]) != 4'd0) e.req_skip = "R1";
      else if (add) e.req_skip = "R3";
      else e.req_skip = "R4";
    end
    if (w == 64) e.req_res = "R11";
    else if (cmp) e.req_res = "R6";
    else if (imm_f) e.req_res = "R7";
    else e.req_res = "R5";
    return e;
  endfunction

  task automatic check_dut(input int k, input logic ov, input logic [63:0] res,
                           input logic sk, input logic eq, input logic lt);
    exp_t e;
    e = pend[k];
    chk(ov === e.vld, "R8", "out_valid", {63'd0, ov}, {63'd0, e.vld});
    if (e.vld) begin
      chk(sk === e.skip, e.req_skip, "skip", {63'd0, sk}, {63'd0, e.skip});
      if (!e.skip && e.is_cmp) begin
        chk(eq === e.eq, e.req_res, "eq", {63'd0, eq}, {63'd0, e.eq});
        chk(lt === e.lt, e.req_res, "lt", {63'd0, lt}, {63'd0, e.lt});
      end else if (!e.skip) begin
        chk(res === e.res, e.req_res, "result", res, e.res);
      end
    end else begin
      chk(res === last_res[k], "R9", "held result", res, last_res[k]);
      chk(sk === last_sk[k], "R9", "held skip", {63'd0, sk}, {63'd0, last_sk[k]});
    end
    last_res[k] = res;
    last_sk[k]  = sk;
  endtask

  task automatic issue(input bit vld, input logic [2:0] op, input logic [63:0] ax32,
                       input logic [63:0] bx32, input logic [63:0] ax64,
                       input logic [63:0] bx64, input logic [15:0] imm,
                       input logic [5:0] spec);
    @(negedge clk);
    check_dut(0, v32, {32'd0, r32}, s32, e32, l32);
    check_dut(1, v64, r64, s64, e64, l64);
    in_valid = vld; in_op = op; in_imm = imm; in_spec = spec;
    a32 = ax32[31:0]; b32 = bx32[31:0]; a64 = ax64; b64 = bx64;
    pend[0] = model(32, vld, op, {32'd0, ax32[31:0]}, {32'd0, bx32[31:0]}, imm, spec);
    pend[1] = model(64, vld, op, ax64, bx64, imm, spec);
  endtask

  function automatic logic [63:0] gen_word(input int w, input logic [5:0] spec);
    logic [63:0] v, mask, pat;
    int sel, tw;
    tw   = int'(spec[5:4]) + 1;
    mask = (64'd1 << tw) - 64'd1;
    pat  = {60'd0, spec[3:0]} & mask;
    v    = {$urandom, $urandom};
    sel  = int'($urandom % 4);
    if (sel == 0) v = 64'($signed(v) >>> (64 - w + 2 + int'($urandom % (w - 4))));
    if (($urandom % 8) != 0) v = (v & ~mask) | pat;
    return v;
  endfunction

  function automatic logic [63:0] edge_word(input int w, input int tw, input bit hi,
                                            input logic [3:0] pat);
    logic [63:0] v;
    v = hi ? ((64'd1 << (w - 1)) - 64'd1) : (64'd1 << (w - 1));
    if (w == 32) v = {32'd0, v[31:0]};
    return (v & ~((64'd1 << tw) - 64'd1)) | ({60'd0, pat} & ((64'd1 << tw) - 64'd1));
  endfunction

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] one32, one64;
    in_valid = 1'b0; in_op = '0; in_imm = '0; in_spec = '0;
    a32 = '0; b32 = '0; a64 = '0; b64 = '0;
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      pend[k] = model(32, 1'b0, 3'b000, 64'd0, 64'd0, 16'd0, 6'd0);
      last_res[k] = '0;
      last_sk[k]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(v32 === 1'b0, "R8", "reset valid32", {63'd0, v32}, 64'd0);
    chk(v64 === 1'b0, "R8", "reset valid64", {63'd0, v64}, 64'd0);
    chk(r32 === 32'd0, "R8", "reset result32", {32'd0, r32}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: field limits for every tag width and both word sizes
    for (int c = 0; c < 4; c++) begin
      one32 = (64'd1 << (c + 1)) | 64'd1;
      one64 = one32;
      // max + 1 overflows (R3), min - 1 overflows (R4)
      issue(1'b1, 3'b000, edge_word(32, c + 1, 1'b1, 4'h1), one32 & 64'hFFFF_FFFF | 64'd0,
            edge_word(64, c + 1, 1'b1, 4'h1), one64, 16'd0, {2'(c), 4'h1});
      issue(1'b1, 3'b001, edge_word(32, c + 1, 1'b0, 4'h1), one32,
            edge_word(64, c + 1, 1'b0, 4'h1), one64, 16'd0, {2'(c), 4'h1});
      // max + 0 fits
      issue(1'b1, 3'b000, edge_word(32, c + 1, 1'b1, 4'h1), 64'd1,
            edge_word(64, c + 1, 1'b1, 4'h1), 64'd1, 16'd0, {2'(c), 4'h1});
      // equal compare, and an immediate whose B operand carries a bad tag
      issue(1'b1, 3'b010, one32, one32, one64, one64, 16'd0, {2'(c), 4'h1});
      issue(1'b1, 3'b100, 64'd1, 64'd0, 64'd1, 64'd0, 16'hFFFF, {2'(c), 4'h1});
      issue(1'b1, 3'b101, edge_word(32, c + 1, 1'b0, 4'h1), 64'd0,
            edge_word(64, c + 1, 1'b0, 4'h1), 64'd0, 16'd1, {2'(c), 4'h1});
      issue(1'b0, 3'b000, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);
    end
    // R1: value bits above a 1-bit tag are ignored
    issue(1'b1, 3'b000, 64'h10, 64'h20, 64'h10, 64'h20, 16'd0, 6'b00_1110);
    // R10: reserved opcodes
    issue(1'b1, 3'b011, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);
    issue(1'b1, 3'b110, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);
    issue(1'b1, 3'b111, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);

    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic [5:0] sp;
      logic [2:0] op;
      int pick;
      sp   = 6'($urandom);
      pick = int'($urandom % 16);
      case (pick)
        0, 1, 2:    op = 3'b000;
        3, 4, 5:    op = 3'b001;
        6, 7, 8:    op = 3'b010;
        9, 10, 11:  op = 3'b100;
        12, 13, 14: op = 3'b101;
        default:    op = 3'($urandom % 8);
      endcase
      issue(($urandom % 6) != 0, op, gen_word(32, sp), gen_word(32, sp),
            gen_word(64, sp), gen_word(64, sp), 16'($urandom), sp);
    end
    issue(1'b0, 3'b000, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);
    issue(1'b0, 3'b000, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, 6'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule